// File: doc/BRIEF.md
# EFM Longest-Run Speed Detector

This block is the coarse speed sensor used while a constant-linear-velocity disc motor is being brought up to speed, before the bit clock has been recovered. It watches the raw EFM level on a fixed crystal-derived sample clock of 8.4672 MHz. It counts how many sample cycles each run of constant level lasts and keeps the longest run seen since the last frame strobe.

At nominal speed the longest run in a frame is the sync pattern. That pattern is two 11T runs, 22T in all, where T is one period of 4.3218 MHz, and it spans 43 sample clocks. On every frame strobe the block latches the frame's longest run and compares it with 43. A longer run means the disc turns too slowly and a shorter one means too fast. From this it drives a direction line and a 7-bit error magnitude that feeds the motor PWM stage. Both outputs are driven together.

The EFM input is assumed to be already synchronous to the sample clock. Data recovery and sync-word decoding are handled elsewhere.

Top module: `efm_run_speed`

## Requirements
- R1: After reset `maxRun` is 43, `slowDir` is 0 and `errMag` is 0.
- R2: A run's length is the number of consecutive rising sample-clock edges at which `efmIn` shows the same level. The count restarts at 1 on the first edge that shows a new level, so runs on either side of a transition never merge.
- R3: A run length saturates at 127 and stays there for a run of any greater length.
- R4: On a rising edge with `frameStrobe` high, `maxRun` takes the largest run length of the frame that is closing. This includes a run completed by a transition in that same cycle and also the run still in progress. The next frame starts with no runs recorded.
- R5: `maxRun`, `slowDir` and `errMag` keep their values on every edge where `frameStrobe` is low.
- R6: `slowDir` is 1 (slow) when `maxRun` > 43. It is 0 (fast, or on speed) when `maxRun` <= 43.
- R7: `errMag` equals min(127, 4 × |`maxRun` − 43|), which is 0 at exactly 43. All outputs reflect the new frame from the cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| efmIn | input | 1 | EFM level, synchronous to clk |
| frameStrobe | input | 1 | One-cycle pulse closing a frame period |
| maxRun | output | 7 | Longest run of the last closed frame, in sample clocks |
| slowDir | output | 1 | Direction line: 1 = motor slow, 0 = fast or on speed |
| errMag | output | 7 | Scaled, saturated speed error magnitude |

## Verification
The frame close and the completion of a run can fall on the same edge. The test provokes this by ending every frame's last run exactly on the strobe cycle. In one directed frame that last run is the longest of the frame, and the test expects it in the closing frame's result. The frame that follows then has only short runs, and its result must not carry the long run forward. The other concurrent case is a strobe in the middle of a run that has passed the saturation limit. There the result must be 127 even though no transition occurred.

// File: rtl/efm_speed_pkg.sv
package efm_speed_pkg;
  typedef struct packed {
    logic levelChange;
    logic frameClose;
  } ctl_strobe_t;
endpackage

// File: rtl/efm_edge_ctrl.sv
module efm_edge_ctrl
  import efm_speed_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        efmIn,
  input  logic        frameStrobe,
  output ctl_strobe_t strb
);
  logic efmQ;

  always_ff @(posedge clk) begin
    if (!rstN) efmQ <= 1'b0;
    else       efmQ <= efmIn;
  end

  always_comb begin
    strb.levelChange = rstN && (efmIn != efmQ);
    strb.frameClose  = rstN && frameStrobe;
  end

  AST_CHANGE_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.levelChange |=> (efmQ == $past(efmIn))); // R2
endmodule

// File: rtl/efm_run_datapath.sv
module efm_run_datapath
  import efm_speed_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int MAG_W      = 7,
  parameter int NOMINAL    = 43,
  parameter int GAIN_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  output logic [CNT_W-1:0] maxRun,
  output logic             slowDir,
  output logic [MAG_W-1:0] errMag
);
  localparam int PROD_W = CNT_W + GAIN_SHIFT;
  localparam logic [CNT_W-1:0] SAT_V = '1;
  localparam logic [CNT_W-1:0] NOM_V = CNT_W'(NOMINAL);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [CNT_W-1:0]  runCnt, curMax, heldMax, frameMax, runNext;
  logic [CNT_W-1:0]  diff;
  logic [PROD_W-1:0] prod;

  always_comb begin
    frameMax = (runCnt > curMax) ? runCnt : curMax;
    if (strb.levelChange)  runNext = CNT_W'(1);
    else if (runCnt == SAT_V) runNext = runCnt;
    else                   runNext = runCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      curMax  <= '0;
      heldMax <= NOM_V;
    end else begin
      runCnt <= runNext;
      if (strb.frameClose) begin
        curMax  <= '0;
        heldMax <= frameMax;
      end else if (strb.levelChange) begin
        curMax <= frameMax;
      end
    end
  end

  always_comb begin
    slowDir = heldMax > NOM_V;
    diff    = slowDir ? (heldMax - NOM_V) : (NOM_V - heldMax);
    prod    = PROD_W'(diff) << GAIN_SHIFT;
    errMag  = (prod > PROD_W'(MAG_MAX)) ? MAG_MAX : prod[MAG_W-1:0];
    maxRun  = heldMax;
  end

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.levelChange |=> (runCnt == CNT_W'(1))); // R2
  AST_RUN_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.levelChange && runCnt != SAT_V) |=> (runCnt == CNT_W'($past(runCnt) + CNT_W'(1)))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.levelChange && runCnt == SAT_V) |=> (runCnt == SAT_V)); // R3
  AST_FRAME_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameClose |=> (curMax == '0)); // R4
  AST_HELD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameClose |=> (heldMax >= $past(runCnt))); // R4
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameClose |=> $stable(heldMax)); // R5
  AST_DIR_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (heldMax <= NOM_V) |-> !slowDir); // R6
  AST_MAG_ON_SPEED: assert property (@(posedge clk) disable iff (!rstN)
    (heldMax == NOM_V) |-> (errMag == '0)); // R7
endmodule

// File: rtl/efm_run_speed.sv
module efm_run_speed
  import efm_speed_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int MAG_W      = 7,
  parameter int NOMINAL    = 43,
  parameter int GAIN_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             efmIn,
  input  logic             frameStrobe,
  output logic [CNT_W-1:0] maxRun,
  output logic             slowDir,
  output logic [MAG_W-1:0] errMag
);
  ctl_strobe_t strb;

  efm_edge_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .efmIn       (efmIn),
    .frameStrobe (frameStrobe),
    .strb        (strb)
  );

  efm_run_datapath #(
    .CNT_W      (CNT_W),
    .MAG_W      (MAG_W),
    .NOMINAL    (NOMINAL),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .maxRun  (maxRun),
    .slowDir (slowDir),
    .errMag  (errMag)
  );
endmodule

// File: tb/efm_run_speed_test.sv
module efm_run_speed_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       efmIn = 1'b0;
  logic       frameStrobe = 1'b0;
  logic [6:0] maxRun;
  logic       slowDir;
  logic [6:0] errMag;

  int checks = 0;
  int failures = 0;
  int runLen[32];
  int nRuns;
  logic curLvl;
  int carry;

  always #5 clk = ~clk;

  efm_run_speed uut (
    .clk(clk), .rstN(rstN), .efmIn(efmIn), .frameStrobe(frameStrobe),
    .maxRun(maxRun), .slowDir(slowDir), .errMag(errMag)
  );

  function automatic int expMag(int m);
    int d;
    d = (m > 43) ? (m - 43) : (43 - m);
    d = d * 4;
    return (d > 127) ? 127 : d;
  endfunction

  function automatic int expMaxRuns();
    int mx = 0;
    for (int i = 0; i < nRuns; i++) begin
      int r;
      r = (runLen[i] > 127) ? 127 : runLen[i];
      if (r > mx) mx = r;
    end
    return mx;
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkOut(int m);
    checkVal("R4 maxRun", int'(maxRun), m);
    checkVal("R6 slowDir", int'(slowDir), (m > 43) ? 1 : 0);
    checkVal("R7 errMag", int'(errMag), expMag(m));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; efmIn = 1'b0; frameStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curLvl = 1'b0;
    carry = 0;
  endtask

  task automatic driveRuns();
    for (int i = 0; i < nRuns; i++) begin
      int n;
      if (!(i == 0 && carry == 1)) curLvl = ~curLvl;
      n = runLen[i] - ((i == 0) ? carry : 0);
      for (int j = 0; j < n; j++) begin
        @(negedge clk);
        efmIn = curLvl;
        frameStrobe = 1'b0;
      end
    end
    carry = 0;
  endtask

  // strobe on the first sample of the next run: last run completes in the strobe cycle
  task automatic closeFrame(int m);
    @(negedge clk);
    curLvl = ~curLvl;
    efmIn = curLvl;
    frameStrobe = 1'b1;
    carry = 1;
    @(posedge clk);
    #2;
    checkOut(m);
  endtask

  task automatic setRuns4(int a, int b, int c, int d, int n);
    runLen[0] = a; runLen[1] = b; runLen[2] = c; runLen[3] = d; nRuns = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();
    #2;
    // R1 reset state
    checkVal("R1 maxRun", int'(maxRun), 43);
    checkVal("R1 slowDir", int'(slowDir), 0);
    checkVal("R1 errMag", int'(errMag), 0);

    // R7 on speed
    setRuns4(5, 8, 43, 7, 4); driveRuns(); closeFrame(expMaxRuns());
    // R6 slow by one
    setRuns4(6, 44, 9, 0, 3); driveRuns(); closeFrame(expMaxRuns());
    // R6 fast by one
    setRuns4(10, 42, 3, 0, 3); driveRuns(); closeFrame(expMaxRuns());
    // R4 longest run completes in the strobe cycle
    setRuns4(4, 6, 50, 0, 3); driveRuns(); closeFrame(50);
    // R4 next frame starts empty
    setRuns4(5, 9, 12, 0, 3); driveRuns(); closeFrame(12);

    // R5 outputs hold while a frame is in progress
    setRuns4(30, 0, 0, 0, 1); driveRuns();
    #2;
    checkVal("R5 maxRun hold", int'(maxRun), 12);
    checkVal("R5 errMag hold", int'(errMag), expMag(12));
    setRuns4(7, 0, 0, 0, 1); driveRuns(); closeFrame(30);

    // R3 saturation of a completed long run
    setRuns4(150, 4, 0, 0, 2); driveRuns(); closeFrame(127);
    // R2 restart at each transition
    setRuns4(20, 3, 20, 0, 3); driveRuns(); closeFrame(20);

    // random frames with an occasional sync-like long run
    for (int f = 0; f < 40; f++) begin
      nRuns = 4 + int'($urandom_range(8));
      for (int i = 0; i < nRuns; i++) runLen[i] = 6 + int'($urandom_range(16));
      if ($urandom_range(3) != 0) runLen[$urandom_range(nRuns - 1)] = 30 + int'($urandom_range(30));
      driveRuns();
      closeFrame(expMaxRuns());
    end

    // R3 R4 stalled disc: strobe in the middle of a saturated run
    setRuns4(200, 0, 0, 0, 1); driveRuns();
    @(negedge clk);
    frameStrobe = 1'b1;
    @(posedge clk);
    #2;
    checkVal("R3 stalled maxRun", int'(maxRun), 127);
    checkVal("R6 stalled slowDir", int'(slowDir), 1);
    checkVal("R7 stalled errMag", int'(errMag), 127);
    @(negedge clk);
    frameStrobe = 1'b0;

    // R1 reset again restores nominal outputs
    doReset();
    #2;
    checkVal("R1 maxRun after reset", int'(maxRun), 43);
    checkVal("R1 slowDir after reset", int'(slowDir), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule